// File: doc/BRIEF.md
# NAND Operation Launch Controller

This block runs one elementary NAND bus operation each time software launches one through a register write. Software first loads a command byte or an address byte into a holding register. It then writes a one-hot launch code. The controller then drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins itself. The supported operations are command latch, address latch, page programming data, page read data, identifier read and status read.

Page read data waits on the ready/busy pin. When the operation ends, the controller sets a sticky completion flag that stays set until software clears it. Page data moves between the NAND bus and an internal dual-port page RAM. The RAM holds one buffer per page, and software reaches it through the same register window. The buffer used by data and identifier transfers comes from a buffer-select register. Status bytes always go to buffer 1.

A driver programs a complete page access as a series of launches. A page read, for example, is command, several address launches, command again, then data output. After each launch the driver polls the completion bit, or waits for the interrupt line.

Top module: `nand_launch_ctrl`

## Requirements
- R1: After reset all NAND strobes are idle: write and read strobes high, command and address latches low, chip enable deasserted, data bus not driven. The completion flag is 0 and every register reads 0.
- R2: A launch write at byte offset 0x1E08 whose code field [5:0] is 0x01 performs one write-strobe pulse with the command latch high. The byte driven during that pulse is bits [7:0] of the command holding register (offset 0x1E00), and bits [15:8] never reach the bus.
- R3: Launch code 0x02 performs one write-strobe pulse with the address latch high. It drives bits [7:0] of the address holding register (offset 0x1E02).
- R4: Every write-strobe and read-strobe low phase lasts exactly TW_LO clocks. The high time between two strobe pulses of one operation is at least TW_HI clocks.
- R5: Launch code 0x04 drives PAGE_BYTES bytes from the selected buffer onto the bus, one write-strobe pulse per byte. Byte i is taken from word i/2, low byte first.
- R6: Launch code 0x08 issues no read-strobe pulse while the ready/busy input is low. Once that input is high, it reads PAGE_BYTES bytes into the selected buffer, low byte of each word first.
- R7: Launch code 0x10 reads ID_BYTES bytes into the selected buffer starting at word 0, without waiting on ready/busy. The other words of that buffer are left unchanged.
- R8: Launch code 0x20 reads one byte and stores it in word 0 of buffer 1 with bits [15:8] cleared, whatever the buffer-select register holds.
- R9: Bit 15 of the launch register is set when an operation ends. It stays set until a write to the launch register with bit 15 at 0. A write with bit 15 at 1 and a zero code leaves it set.
- R10: A launch write that arrives while an operation is running starts nothing and leaves the running operation unchanged.
- R11: A launch write whose code field has zero bits or more than one bit set starts no operation.
- R12: The control register (offset 0x1E06) keeps only bits 2 (spare-only), 3 (ECC enable), 4 (interrupt mask) and 7 (chip enable); all other bits read 0. Bit 7 high asserts the active-low chip enable. The interrupt output equals the completion flag while bit 4 is 0, and is 0 while bit 4 is 1.
- R13: Word w of buffer b is read and written by software at byte offset 0x200*b + 2*w, for b below NUM_BUFS and w below PAGE_BYTES/2. The buffer-select register is at offset 0x1E04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register/RAM write strobe |
| host_addr | input | 13 | Byte offset into the register window |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| irq | output | 1 | Completion interrupt, gated by mask bit |
| nand_ce_n | output | 1 | Active-low chip enable |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_rb_n | input | 1 | Ready (high) / busy (low) from the flash |
| nand_dq_in | input | 8 | Data bus from the flash |
| nand_dq_out | output | 8 | Data bus to the flash |
| nand_dq_oe | output | 1 | Data bus output enable |

## Verification
The bench builds the controller with a 16-byte page and two buffers, so a full page transfer takes only a few dozen cycles. That short page lets many random pages and both buffer selections run in one run. It uses a 4-byte identifier read, which leaves the tail of an 8-word buffer available to confirm that words past the identifier stay unchanged. The strobe timing is asymmetric, with a 3-clock low and a 2-clock high, so a swapped or miscounted phase shows up in the measured pulse widths.

// File: rtl/nandl_pkg.sv
package nandl_pkg;

    localparam int ADDR_W = 13;

    // Register window offsets (bytes)
    localparam logic [ADDR_W-1:0] OFS_CMD = 13'h1E00;
    localparam logic [ADDR_W-1:0] OFS_ADR = 13'h1E02;
    localparam logic [ADDR_W-1:0] OFS_BUF = 13'h1E04;
    localparam logic [ADDR_W-1:0] OFS_CTL = 13'h1E06;
    localparam logic [ADDR_W-1:0] OFS_GO  = 13'h1E08;

    localparam int BUF_STRIDE_LOG = 9;   // 0x200 bytes per buffer slot
    localparam int DONE_BIT       = 15;
    localparam int STATUS_BUF     = 1;

    localparam int CTL_SPARE = 2;
    localparam int CTL_ECC   = 3;
    localparam int CTL_IMASK = 4;
    localparam int CTL_CE    = 7;
    localparam logic [15:0] CTL_KEEP = 16'h009C;

    // One-hot launch codes
    localparam logic [5:0] LC_CMD  = 6'h01;
    localparam logic [5:0] LC_ADR  = 6'h02;
    localparam logic [5:0] LC_DIN  = 6'h04;
    localparam logic [5:0] LC_DOUT = 6'h08;
    localparam logic [5:0] LC_ID   = 6'h10;
    localparam logic [5:0] LC_STAT = 6'h20;

    typedef enum logic [2:0] {
        OP_NONE, OP_CMD, OP_ADR, OP_DIN, OP_DOUT, OP_ID, OP_STAT
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE, S_WAIT_RB, S_LO, S_HI
    } seq_st_e;

    typedef struct packed {
        logic cle;
        logic ale;
        logic we_n;
        logic re_n;
        logic oe;
    } strobe_t;

    function automatic op_e decode_launch(input logic [5:0] code);
        case (code)
            LC_CMD:  return OP_CMD;
            LC_ADR:  return OP_ADR;
            LC_DIN:  return OP_DIN;
            LC_DOUT: return OP_DOUT;
            LC_ID:   return OP_ID;
            LC_STAT: return OP_STAT;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic op_reads(input op_e op);
        return (op == OP_DOUT) || (op == OP_ID) || (op == OP_STAT);
    endfunction

    function automatic logic op_writes(input op_e op);
        return (op == OP_CMD) || (op == OP_ADR) || (op == OP_DIN);
    endfunction

endpackage

// File: rtl/nandl_page_ram.sv
module nandl_page_ram #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [15:0]   a_wdata,
    output logic [15:0]   a_rdata,
    input  logic          b_we,
    input  logic [1:0]    b_be,
    input  logic [AW-1:0] b_addr,
    input  logic [15:0]   b_wdata,
    output logic [15:0]   b_rdata
);

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (a_we)
                mem[a_addr] <= a_wdata[ln*8 +: 8];
            if (b_we && b_be[ln])
                mem[b_addr] <= b_wdata[ln*8 +: 8];
        end

        assign a_rdata[ln*8 +: 8] = mem[a_addr];
        assign b_rdata[ln*8 +: 8] = mem[b_addr];
    end

endmodule

// File: rtl/nandl_regs.sv
module nandl_regs
    import nandl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              busy,
    input  logic              op_end,
    output logic [15:0]       cmd_q,
    output logic [15:0]       adr_q,
    output logic [15:0]       buf_q,
    output logic [15:0]       ctl_q,
    output logic              done,
    output logic              start,
    output op_e               start_op,
    output logic              reg_hit,
    output logic [15:0]       reg_rdata
);

    logic go_wr;

    assign go_wr    = wr && (addr == OFS_GO);
    assign start_op = decode_launch(wdata[5:0]);
    assign start    = go_wr && !busy && (start_op != OP_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            adr_q <= '0;
            buf_q <= '0;
            ctl_q <= '0;
            done  <= 1'b0;
        end else begin
            if (wr && addr == OFS_CMD) cmd_q <= wdata;
            if (wr && addr == OFS_ADR) adr_q <= wdata;
            if (wr && addr == OFS_BUF) buf_q <= wdata;
            if (wr && addr == OFS_CTL) ctl_q <= wdata & CTL_KEEP;
            // hardware completion wins over a software clear in the same cycle
            if (op_end)
                done <= 1'b1;
            else if (go_wr && !wdata[DONE_BIT])
                done <= 1'b0;
        end
    end

    always_comb begin
        reg_hit   = 1'b1;
        reg_rdata = '0;
        case (addr)
            OFS_CMD: reg_rdata = cmd_q;
            OFS_ADR: reg_rdata = adr_q;
            OFS_BUF: reg_rdata = buf_q;
            OFS_CTL: reg_rdata = ctl_q;
            OFS_GO:  reg_rdata = {done, 15'b0};
            default: reg_hit   = 1'b0;
        endcase
    end

endmodule

// File: rtl/nandl_seq.sv
module nandl_seq
    import nandl_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int ID_BYTES   = 4,
    parameter int TW_LO      = 2,
    parameter int TW_HI      = 2,
    parameter int NUM_BUFS   = 2,
    localparam int BUF_W  = $clog2(NUM_BUFS),
    localparam int PB_AW  = $clog2(PAGE_BYTES),
    localparam int PW_AW  = PB_AW - 1,
    localparam int RAM_AW = BUF_W + PW_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_e               start_op,
    input  logic [7:0]        cmd_byte,
    input  logic [7:0]        adr_byte,
    input  logic [BUF_W-1:0]  buf_sel,
    input  logic              rb_n,
    input  logic [7:0]        dq_in,
    input  logic [15:0]       ram_rdata,
    output logic              busy,
    output logic              op_end,
    output op_e               cur_op,
    output strobe_t           strb,
    output logic [7:0]        dq_out,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [1:0]        ram_be,
    output logic [15:0]       ram_wdata
);

    localparam int TW_MAX = (TW_LO > TW_HI) ? TW_LO : TW_HI;
    localparam int CNT_W  = $clog2(TW_MAX) + 1;
    localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(TW_LO - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(TW_HI - 1);
    localparam logic [PB_AW-1:0] PAGE_LAST = PB_AW'(PAGE_BYTES - 1);
    localparam logic [PB_AW-1:0] ID_LAST   = PB_AW'(ID_BYTES - 1);
    localparam logic [BUF_W-1:0] STAT_SEL  = BUF_W'(STATUS_BUF);

    seq_st_e          st;
    op_e              op;
    logic [CNT_W-1:0] cnt;
    logic [PB_AW-1:0] idx;
    logic [PB_AW-1:0] last_idx;
    logic [BUF_W-1:0] buf_lat;
    logic [7:0]       byte_lat;
    logic [1:0]       rb_sync;
    logic             last_byte;
    logic             active;
    logic [BUF_W-1:0] tgt_buf;

    always_comb begin
        case (op)
            OP_DIN, OP_DOUT: last_idx = PAGE_LAST;
            OP_ID:           last_idx = ID_LAST;
            default:         last_idx = '0;
        endcase
    end

    assign last_byte = (idx == last_idx);
    assign active    = (st == S_LO) || (st == S_HI);
    assign busy      = (st != S_IDLE);
    assign op_end    = (st == S_HI) && (cnt == HI_LAST) && last_byte;
    assign cur_op    = op;
    assign tgt_buf   = (op == OP_STAT) ? STAT_SEL : buf_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            op       <= OP_NONE;
            cnt      <= '0;
            idx      <= '0;
            buf_lat  <= '0;
            byte_lat <= '0;
            rb_sync  <= 2'b00;
        end else begin
            rb_sync <= {rb_sync[0], rb_n};
            unique case (st)
                S_IDLE: if (start) begin
                    op       <= start_op;
                    buf_lat  <= buf_sel;
                    byte_lat <= (start_op == OP_ADR) ? adr_byte : cmd_byte;
                    cnt      <= '0;
                    idx      <= '0;
                    st       <= (start_op == OP_DOUT) ? S_WAIT_RB : S_LO;
                end
                S_WAIT_RB: if (rb_sync[1]) st <= S_LO;
                S_LO: begin
                    if (cnt == LO_LAST) begin
                        cnt <= '0;
                        st  <= S_HI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_HI: begin
                    if (cnt == HI_LAST) begin
                        cnt <= '0;
                        if (last_byte) begin
                            st <= S_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= S_LO;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Bus strobes decoded from registered state
    always_comb begin
        strb.cle  = active && (op == OP_CMD);
        strb.ale  = active && (op == OP_ADR);
        strb.we_n = !((st == S_LO) && op_writes(op));
        strb.re_n = !((st == S_LO) && op_reads(op));
        strb.oe   = active && op_writes(op);
    end

    always_comb begin
        if (op == OP_DIN)
            dq_out = idx[0] ? ram_rdata[15:8] : ram_rdata[7:0];
        else
            dq_out = byte_lat;
    end

    // Captured byte is written at the last clock of the read-strobe low phase
    assign ram_addr  = {tgt_buf, idx[PB_AW-1:1]};
    assign ram_we    = (st == S_LO) && (cnt == LO_LAST) && op_reads(op);
    assign ram_be    = (op == OP_STAT) ? 2'b11 : (idx[0] ? 2'b10 : 2'b01);
    assign ram_wdata = (op == OP_STAT) ? {8'h00, dq_in} : {dq_in, dq_in};

endmodule

// File: rtl/nand_launch_ctrl.sv
module nand_launch_ctrl
    import nandl_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int ID_BYTES   = 4,
    parameter int TW_LO      = 2,
    parameter int TW_HI      = 2,
    parameter int NUM_BUFS   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [12:0]       host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              irq,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    input  logic              nand_rb_n,
    input  logic [7:0]        nand_dq_in,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe
);

    localparam int PB_AW      = $clog2(PAGE_BYTES);
    localparam int PW_AW      = PB_AW - 1;
    localparam int PAGE_WORDS = PAGE_BYTES / 2;
    localparam int BUF_W      = $clog2(NUM_BUFS);
    localparam int RAM_AW     = BUF_W + PW_AW;
    localparam int RAM_DEPTH  = NUM_BUFS * PAGE_WORDS;
    localparam logic [2:0] NB_LIM = 3'(NUM_BUFS);
    localparam logic [8:0] PW_LIM = 9'(PAGE_WORDS);

    logic [15:0]       cmd_q, adr_q, buf_q, ctl_q, reg_rdata, ram_a_rdata, ram_b_rdata, ram_b_wdata;
    logic              done_w, start_w, busy_w, op_end_w, reg_hit;
    op_e               start_op_w, cur_op;
    strobe_t           strb;
    logic [RAM_AW-1:0] ram_a_addr, ram_b_addr;
    logic              ram_a_we, ram_b_we, ram_hit;
    logic [1:0]        ram_b_be;
    logic [2:0]        a_buf_field;
    logic [7:0]        a_word_field;

    nandl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (host_wr),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .busy      (busy_w),
        .op_end    (op_end_w),
        .cmd_q     (cmd_q),
        .adr_q     (adr_q),
        .buf_q     (buf_q),
        .ctl_q     (ctl_q),
        .done      (done_w),
        .start     (start_w),
        .start_op  (start_op_w),
        .reg_hit   (reg_hit),
        .reg_rdata (reg_rdata)
    );

    nandl_seq #(
        .PAGE_BYTES (PAGE_BYTES),
        .ID_BYTES   (ID_BYTES),
        .TW_LO      (TW_LO),
        .TW_HI      (TW_HI),
        .NUM_BUFS   (NUM_BUFS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_w),
        .start_op  (start_op_w),
        .cmd_byte  (cmd_q[7:0]),
        .adr_byte  (adr_q[7:0]),
        .buf_sel   (buf_q[BUF_W-1:0]),
        .rb_n      (nand_rb_n),
        .dq_in     (nand_dq_in),
        .ram_rdata (ram_b_rdata),
        .busy      (busy_w),
        .op_end    (op_end_w),
        .cur_op    (cur_op),
        .strb      (strb),
        .dq_out    (nand_dq_out),
        .ram_addr  (ram_b_addr),
        .ram_we    (ram_b_we),
        .ram_be    (ram_b_be),
        .ram_wdata (ram_b_wdata)
    );

    // Host side of the page RAM: buffer slot every 0x200 bytes
    assign a_buf_field  = host_addr[11:BUF_STRIDE_LOG];
    assign a_word_field = host_addr[BUF_STRIDE_LOG-1:1];
    assign ram_hit      = !host_addr[12] && (a_buf_field < NB_LIM) && ({1'b0, a_word_field} < PW_LIM);
    assign ram_a_addr   = {a_buf_field[BUF_W-1:0], a_word_field[PW_AW-1:0]};
    assign ram_a_we     = host_wr && ram_hit;

    nandl_page_ram #(
        .DEPTH (RAM_DEPTH)
    ) u_ram (
        .clk     (clk),
        .a_we    (ram_a_we),
        .a_addr  (ram_a_addr),
        .a_wdata (host_wdata),
        .a_rdata (ram_a_rdata),
        .b_we    (ram_b_we),
        .b_be    (ram_b_be),
        .b_addr  (ram_b_addr),
        .b_wdata (ram_b_wdata),
        .b_rdata (ram_b_rdata)
    );

    assign host_rdata = reg_hit ? reg_rdata : (ram_hit ? ram_a_rdata : 16'h0000);
    assign irq        = done_w && !ctl_q[CTL_IMASK];
    assign nand_ce_n  = !ctl_q[CTL_CE];
    assign nand_cle   = strb.cle;
    assign nand_ale   = strb.ale;
    assign nand_we_n  = strb.we_n;
    assign nand_re_n  = strb.re_n;
    assign nand_dq_oe = strb.oe;

endmodule

// File: rtl/nandl_checker.sv
module nandl_checker
    import nandl_pkg::*;
#(
    parameter int TW_LO = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        host_wr,
    input logic [12:0] host_addr,
    input logic [15:0] host_wdata,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_dq_oe,
    input logic        done_w,
    input logic        busy_w,
    input op_e         cur_op
);

    logic [7:0] we_lo_cnt, re_lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            re_lo_cnt <= '0;
        end else begin
            we_lo_cnt <= nand_we_n ? 8'd0 : we_lo_cnt + 8'd1;
            re_lo_cnt <= nand_re_n ? 8'd0 : re_lo_cnt + 8'd1;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !done_w));

    a_r2_latch_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    a_r4_we_low_width: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |-> (we_lo_cnt == 8'(TW_LO)));

    a_r4_re_low_width: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_re_n) |-> (re_lo_cnt == 8'(TW_LO)));

    a_r5_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> (nand_dq_oe && nand_re_n));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_w && !(host_wr && host_addr == OFS_GO && !host_wdata[DONE_BIT])) |=> done_w);

    a_r10_busy_ignores_launch: assert property (@(posedge clk) disable iff (rst)
        (busy_w && host_wr && host_addr == OFS_GO) |=> $stable(cur_op));

endmodule

bind nand_launch_ctrl nandl_checker #(.TW_LO(TW_LO)) u_nandl_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .done_w     (done_w),
    .busy_w     (busy_w),
    .cur_op     (cur_op)
);

// File: tb/nand_launch_ctrl_test.sv
module nand_launch_ctrl_test;
    import nandl_pkg::*;

    localparam int PB  = 16;
    localparam int IDB = 4;
    localparam int TLO = 3;
    localparam int THI = 2;
    localparam int NB  = 2;
    localparam int PW  = PB / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [12:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        irq, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic        nand_rb_n = 1'b1;
    logic [7:0]  nand_dq_in, nand_dq_out;

    always #2.5 clk = ~clk;

    nand_launch_ctrl #(
        .PAGE_BYTES (PB), .ID_BYTES (IDB), .TW_LO (TLO), .TW_HI (THI), .NUM_BUFS (NB)
    ) uut (
        .clk (clk), .rst (rst), .host_wr (host_wr), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_rdata (host_rdata), .irq (irq),
        .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_ale (nand_ale),
        .nand_we_n (nand_we_n), .nand_re_n (nand_re_n), .nand_rb_n (nand_rb_n),
        .nand_dq_in (nand_dq_in), .nand_dq_out (nand_dq_out), .nand_dq_oe (nand_dq_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Flash model
    logic [7:0] src [64];
    int sptr = 0;
    assign nand_dq_in = src[sptr % 64];
    int re_falls = 0, we_falls = 0, cmd_n = 0, adr_n = 0, din_n = 0;
    logic [7:0] last_cmd, last_adr;
    logic [7:0] din [64];

    always @(posedge nand_re_n) if (!rst) sptr = sptr + 1;
    always @(negedge nand_re_n) if (!rst) re_falls++;
    always @(negedge nand_we_n) if (!rst) we_falls++;
    always @(posedge nand_we_n) begin
        if (!rst) begin
            if (nand_cle) begin cmd_n++; last_cmd = nand_dq_out; end
            else if (nand_ale) begin adr_n++; last_adr = nand_dq_out; end
            else begin din[din_n % 64] = nand_dq_out; din_n++; end
        end
    end

    // Strobe width monitor
    int lo_run = 0, last_lo = 0, hi_run = 0, hi_min = 999, re_run = 0, last_re_lo = 0;
    bit seen_pulse = 0;
    always @(negedge clk) begin
        if (!nand_we_n) begin
            if (lo_run == 0 && seen_pulse && hi_run < hi_min) hi_min = hi_run;
            lo_run++; hi_run = 0;
        end else begin
            if (lo_run > 0) begin last_lo = lo_run; seen_pulse = 1; end
            lo_run = 0; hi_run++;
        end
        if (!nand_re_n) re_run++;
        else begin if (re_run > 0) last_re_lo = re_run; re_run = 0; end
    end

    logic [15:0] shadow [NB][PW];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [12:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [12:0] a, output logic [15:0] v);
        @(negedge clk);
        host_addr = a;
        #1 v = host_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [15:0] v;
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            hr(OFS_GO, v);
            if (v[15]) begin ok = 1; return; end
        end
    endtask

    function automatic logic [12:0] ram_ofs(input int b, input int w);
        return 13'(b * 512 + w * 2);
    endfunction

    function automatic logic [7:0] sh_byte(input int b, input int i);
        return i[0] ? shadow[b][i/2][15:8] : shadow[b][i/2][7:0];
    endfunction

    task automatic fill_buf(input int b);
        for (int w = 0; w < PW; w++) begin
            shadow[b][w] = 16'($urandom);
            hw(ram_ofs(b, w), shadow[b][w]);
        end
    endtask

    task automatic check_buf(input int b, input string req);
        logic [15:0] v;
        for (int w = 0; w < PW; w++) begin
            hr(ram_ofs(b, w), v);
            chk(v == shadow[b][w], req, int'(v), int'(shadow[b][w]));
        end
    endtask

    initial begin
        logic [15:0] v, d;
        bit ok;
        int n0, b;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && nand_ce_n,
            "R1 idle strobes", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, nand_ce_n}, 6'b110001);
        hr(OFS_GO, v);  chk(v == 16'h0, "R1 launch reg", v, 0);
        hr(OFS_CTL, v); chk(v == 16'h0, "R1 control reg", v, 0);
        hr(OFS_CMD, v); chk(v == 16'h0, "R1 command reg", v, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R12 control register bits
        hw(OFS_CTL, 16'hFFFF);
        hr(OFS_CTL, v); chk(v == 16'h009C, "R12 control mask", v, 16'h009C);
        chk(nand_ce_n == 1'b0, "R12 chip enable", nand_ce_n, 0);
        hw(OFS_CTL, 16'h0080);

        // R13 buffer map
        fill_buf(0); fill_buf(1);
        check_buf(0, "R13 buffer0 readback");
        check_buf(1, "R13 buffer1 readback");
        hr(13'h200, v); chk(v == shadow[1][0], "R13 0x200 is buffer1 word0", v, shadow[1][0]);

        // R2 / R3 / R4 / R9 command and address launches with random data
        for (int k = 0; k < 6; k++) begin
            d = 16'($urandom);
            n0 = cmd_n;
            hw(OFS_CMD, d); hw(OFS_GO, 16'(LC_CMD));
            wait_done(ok);
            chk(ok, "R9 done after command", ok, 1);
            chk(cmd_n == n0 + 1 && last_cmd == d[7:0], "R2 command byte", last_cmd, d[7:0]);
            chk(last_lo == TLO, "R4 write low width", last_lo, TLO);
            chk(irq == 1'b1, "R12 irq follows done", irq, 1);
            d = 16'($urandom);
            n0 = adr_n;
            hw(OFS_ADR, d); hw(OFS_GO, 16'(LC_ADR));
            wait_done(ok);
            chk(ok && adr_n == n0 + 1 && last_adr == d[7:0], "R3 address byte", last_adr, d[7:0]);
        end

        // R5 page data to flash
        for (int k = 0; k < 3; k++) begin
            b = k % 2;
            fill_buf(b);
            hw(OFS_BUF, 16'(b));
            @(negedge clk);
            din_n = 0; seen_pulse = 0; hi_min = 999;
            hw(OFS_GO, 16'(LC_DIN));
            wait_done(ok);
            chk(ok && din_n == PB, "R5 byte count", din_n, PB);
            for (int i = 0; i < PB; i++)
                chk(din[i] == sh_byte(b, i), "R5 page byte", din[i], sh_byte(b, i));
            chk(hi_min >= THI, "R4 write high width", hi_min, THI);
        end

        // R6 page data from flash, gated by ready/busy
        for (int k = 0; k < 3; k++) begin
            b = (k + 1) % 2;
            for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
            hw(OFS_BUF, 16'(b));
            nand_rb_n = 1'b0;
            @(negedge clk); sptr = 0;
            n0 = re_falls;
            hw(OFS_GO, 16'(LC_DOUT));
            repeat (20) @(negedge clk);
            chk(re_falls == n0, "R6 no read strobe while busy", re_falls - n0, 0);
            hr(OFS_GO, v); chk(v[15] == 1'b0, "R6 not done while busy", v[15], 0);
            nand_rb_n = 1'b1;
            wait_done(ok);
            chk(ok && re_falls == n0 + PB, "R6 read strobe count", re_falls - n0, PB);
            chk(last_re_lo == TLO, "R4 read low width", last_re_lo, TLO);
            for (int w = 0; w < PW; w++) shadow[b][w] = {src[2*w+1], src[2*w]};
            check_buf(b, "R6 page stored");
        end

        // R7 identifier read ignores ready/busy
        fill_buf(0);
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        hw(OFS_BUF, 16'h0000);
        nand_rb_n = 1'b0;
        @(negedge clk); sptr = 0;
        hw(OFS_GO, 16'(LC_ID));
        wait_done(ok);
        chk(ok, "R7 id completes with busy low", ok, 1);
        nand_rb_n = 1'b1;
        for (int w = 0; w < IDB / 2; w++) shadow[0][w] = {src[2*w+1], src[2*w]};
        check_buf(0, "R7 id bytes and untouched tail");

        // R8 status read goes to buffer 1 word 0
        fill_buf(0); fill_buf(1);
        hw(OFS_BUF, 16'h0000);
        @(negedge clk); sptr = 0; src[0] = 8'($urandom) | 8'h40;
        hw(OFS_GO, 16'(LC_STAT));
        wait_done(ok);
        shadow[1][0] = {8'h00, src[0]};
        hr(ram_ofs(1, 0), v); chk(ok && v == shadow[1][0], "R8 status word", v, shadow[1][0]);
        hr(ram_ofs(0, 0), v); chk(v == shadow[0][0], "R8 buffer0 untouched", v, shadow[0][0]);

        // R9 sticky flag and R12 mask
        hw(OFS_GO, 16'h8000);
        hr(OFS_GO, v); chk(v[15] == 1'b1, "R9 write with bit15 set keeps flag", v[15], 1);
        hw(OFS_CTL, 16'h0090);
        chk(irq == 1'b0, "R12 irq masked", irq, 0);
        hw(OFS_CTL, 16'h0080);
        hw(OFS_GO, 16'h0000);
        hr(OFS_GO, v); chk(v[15] == 1'b0, "R9 clear by writing bit15 zero", v[15], 0);
        chk(irq == 1'b0, "R12 irq after clear", irq, 0);

        // R10 launch while running
        fill_buf(1);
        hw(OFS_BUF, 16'h0001);
        hw(OFS_CMD, 16'h00A5);
        n0 = cmd_n; din_n = 0;
        hw(OFS_GO, 16'(LC_DIN));
        hw(OFS_GO, 16'(LC_CMD));
        wait_done(ok);
        repeat (20) @(negedge clk);
        chk(ok && din_n == PB, "R10 running transfer intact", din_n, PB);
        chk(cmd_n == n0, "R10 second launch ignored", cmd_n - n0, 0);

        // R11 malformed codes
        n0 = we_falls + re_falls;
        hw(OFS_GO, 16'h0000);
        hw(OFS_GO, 16'h0003);
        hw(OFS_GO, 16'h0018);
        hw(OFS_GO, 16'h0040);
        repeat (20) @(negedge clk);
        chk(we_falls + re_falls == n0, "R11 no strobe activity", we_falls + re_falls - n0, 0);
        hr(OFS_GO, v); chk(v[15] == 1'b0, "R11 no completion", v[15], 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule